// File: doc/BRIEF.md
# Descriptor-Driven Register Capture Engine

This block walks a short program of 32-bit command words held in a descriptor memory and performs the accesses it describes on a target bus. The program can read runs of consecutive words, write a value, apply a masked read-modify-write, and loop back over the preceding words a set number of times. Every value the engine reads from the target is appended, in order, to a capture SRAM starting at capture address 0. The purpose is to snapshot a set of registers when software asks for it or when a crash signal fires, so that the values can be inspected afterwards.

The engine starts from descriptor word 0 on a software trigger pulse, or on a rising edge of the crash trigger, but only while enable is high. An entry that targets a register uses one header word and then one to three argument words. The descriptor memory has a registered read port, so each fetched word costs two cycles. The target bus is a request/acknowledge port: a request is held stable until a one-cycle acknowledge arrives.

Top module: `capture_engine`

## Requirements
- R1: After reset, status is 2'b00, bus_req is low and cap_we is low.
- R2: Bits [31:30] of a header select its kind. 00 is a register entry, 01 is a loop, 10 is read-modify-write and 11 is a link that ends the run. An all-zero header also ends the run.
- R3: A register entry with bit 28 clear is a read run. Its header gives the base address in bits [27:4] (16-byte aligned). One argument word follows, carrying a word offset in bits [9:2] and a count N in bits [22:16]. The engine reads N words at base+4*offset+4*k for k from 0 upward, and writes them to capture addresses 0, 1, 2 and so on. A count of 0 or 1 reads one word.
- R4: A register entry with bit 28 set writes. It takes the same argument word plus a second one holding the data, and writes that data once to base+4*offset. Nothing is logged for a write.
- R5: Header bit 29 is driven on bus_alt during every access of that entry, selecting the alternate bus.
- R6: A read-modify-write entry (base in bits [27:4]) takes three argument words: offset word, mask, value. It reads the target and logs the old value. It then writes (old AND NOT mask) OR (value AND mask) back to the same address.
- R7: A loop header holds a count in bits [7:0] and a span in bits [23:16]. The span words just before the loop header are executed count times in total, each pass logging new values. A count of 0 or 1 gives a single pass.
- R8: A run starts on sw_trig, or on a rising edge of crash_trig, only while en is high. With en low, triggers have no effect. A crash_trig held high starts exactly one run.
- R9: status[0] is high while a run is in progress and low otherwise, and bus_req is low whenever status[0] is low. The capture SRAM can fill up: all 2**CAP_AW words written and another read is due. In that case the engine issues no further access and writes nothing more. It sets status[1] and goes idle. status[1] stays set until the next run starts.
- R10: Once bus_req is raised, bus_req, bus_addr and bus_we stay constant until the cycle in which bus_ack is high. Each acknowledge completes exactly one access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Allows triggers to start a run |
| sw_trig | input | 1 | Software trigger pulse |
| crash_trig | input | 1 | Crash trigger level, acted on at its rising edge |
| desc_addr | output | DESC_AW | Descriptor memory word address |
| desc_rdata | input | 32 | Descriptor word, valid one cycle after desc_addr |
| bus_req | output | 1 | Target access request |
| bus_we | output | 1 | Access is a write |
| bus_alt | output | 1 | Access goes to the alternate bus |
| bus_addr | output | 32 | Target byte address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | One-cycle completion of the current access |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| cap_we | output | 1 | Capture SRAM write strobe |
| cap_addr | output | CAP_AW | Capture SRAM word address |
| cap_wdata | output | 32 | Captured word |
| status | output | 2 | Bit 0 busy, bit 1 capture overflow |

## Verification
The hardest condition to reach is a loop that must produce fresh values on every pass. With a plain memory as the target, each pass returns the same data, and a wrong pass count can hide behind repeated values. The bench target therefore has one register that returns an incrementing count on every read. Loop lists read it, so the captured sequence 0, 1, 2 and so on shows how many passes ran, in what order. Capture overflow is reached with a read run longer than the capture SRAM, and the read-modify-write merge is swept over masks that keep nothing, everything and mixed bits.

// File: rtl/cpe_pkg.sv
package cpe_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_HDR, S_ARG, S_RD, S_WR, S_MRD, S_MWR
  } cpe_state_t;

  typedef enum logic [1:0] {
    K_REG  = 2'b00,
    K_LOOP = 2'b01,
    K_RMW  = 2'b10,
    K_LINK = 2'b11
  } cpe_kind_t;

  // base field (header bits [27:4]) plus word offset plus run index, in bytes
  function automatic logic [WORD_W-1:0] cpe_target(input logic [23:0] base,
                                                   input logic [7:0]  off,
                                                   input logic [6:0]  idx);
    return {4'h0, base, 4'h0} + {22'h0, off, 2'b00} + {23'h0, idx, 2'b00};
  endfunction

endpackage

// File: rtl/cpe_loop.sv
module cpe_loop #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hit,
  input  logic [CNT_W-1:0] cnt,
  output logic             back
);

  logic             act_q, act_d;
  logic [CNT_W-1:0] left_q, left_d;

  always_comb begin
    act_d  = act_q;
    left_d = left_q;
    back   = 1'b0;
    if (clr) begin
      act_d  = 1'b0;
      left_d = '0;
    end else if (hit) begin
      if (act_q) begin
        if (left_q != '0) begin
          back   = 1'b1;
          left_d = left_q - CNT_W'(1);
        end else begin
          act_d = 1'b0;
        end
      end else if (cnt > CNT_W'(1)) begin
        back   = 1'b1;
        act_d  = 1'b1;
        left_d = cnt - CNT_W'(2);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      left_q <= '0;
    end else begin
      act_q  <= act_d;
      left_q <= left_d;
    end
  end

endmodule

// File: rtl/cpe_capture.sv
module cpe_capture #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  output logic          full,
  output logic          cap_we,
  output logic [AW-1:0] cap_addr,
  output logic [DW-1:0] cap_wdata
);

  logic [AW:0] ptr_q, ptr_d;

  assign full = ptr_q[AW];

  always_comb begin
    ptr_d = ptr_q;
    if (clr)       ptr_d = '0;
    else if (push) ptr_d = ptr_q + (AW+1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      cap_we    <= 1'b0;
      cap_addr  <= '0;
      cap_wdata <= '0;
    end else begin
      ptr_q  <= ptr_d;
      cap_we <= push && !clr;
      if (push) begin
        cap_addr  <= ptr_q[AW-1:0];
        cap_wdata <= din;
      end
    end
  end

endmodule

// File: rtl/cpe_ctrl.sv
module cpe_ctrl
  import cpe_pkg::*;
#(
  parameter int DESC_AW = 5,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               sw_trig,
  input  logic               crash_trig,
  output logic [DESC_AW-1:0] desc_addr,
  input  logic [WORD_W-1:0]  desc_rdata,
  output logic               bus_req,
  output logic               bus_we,
  output logic               bus_alt,
  output logic [WORD_W-1:0]  bus_addr,
  output logic [WORD_W-1:0]  bus_wdata,
  input  logic               bus_ack,
  input  logic [WORD_W-1:0]  bus_rdata,
  output logic [1:0]         status,
  output logic               loop_hit,
  output logic [CNT_W-1:0]   loop_cnt,
  input  logic               loop_back,
  output logic               run_clr,
  output logic               cap_push,
  output logic [WORD_W-1:0]  cap_data,
  input  logic               cap_full
);

  localparam logic [DESC_AW-1:0] PC_TOP = '1;

  cpe_state_t         state_q, state_d;
  logic [DESC_AW-1:0] pc_q, pc_d;
  logic [27:0]        hdr_q, hdr_d;      // header bits [31:4]
  logic [7:0]         off_q, off_d;
  logic [6:0]         len_q, len_d;
  logic [WORD_W-1:0]  a1_q, a1_d, a2_q, a2_d, old_q, old_d;
  logic [1:0]         argi_q, argi_d, need_q, need_d;
  logic [6:0]         ridx_q, ridx_d;
  logic               args_q, args_d, last_q, last_d, ovf_q, ovf_d, crash_q;

  cpe_kind_t   kind;
  logic        start, at_top, run_end;
  logic [7:0]  run_n;

  assign kind      = cpe_kind_t'(desc_rdata[31:30]);
  assign start     = en && (sw_trig || (crash_trig && !crash_q));
  assign at_top    = (pc_q == PC_TOP);
  assign run_n     = (len_q == 7'd0) ? 8'd1 : {1'b0, len_q};
  assign run_end   = ({1'b0, ridx_q} + 8'd1) >= run_n;
  assign desc_addr = pc_q;
  assign bus_addr  = cpe_target(hdr_q[23:0], off_q, ridx_q);
  assign bus_alt   = hdr_q[25];
  assign bus_we    = (state_q == S_WR) || (state_q == S_MWR);
  assign bus_wdata = (state_q == S_WR) ? a1_q : ((old_q & ~a1_q) | (a2_q & a1_q));
  assign status    = {ovf_q, state_q != S_IDLE};
  assign cap_data  = bus_rdata;
  assign loop_cnt  = desc_rdata[CNT_W-1:0];

  always_comb begin
    state_d  = state_q;
    pc_d     = pc_q;
    hdr_d    = hdr_q;
    off_d    = off_q;
    len_d    = len_q;
    a1_d     = a1_q;
    a2_d     = a2_q;
    old_d    = old_q;
    argi_d   = argi_q;
    need_d   = need_q;
    ridx_d   = ridx_q;
    args_d   = args_q;
    last_d   = last_q;
    ovf_d    = ovf_q;
    bus_req  = 1'b0;
    loop_hit = 1'b0;
    run_clr  = 1'b0;
    cap_push = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          state_d = S_FETCH;
          pc_d    = '0;
          ovf_d   = 1'b0;
          args_d  = 1'b0;
          last_d  = 1'b0;
          run_clr = 1'b1;
        end
      end
      S_FETCH: state_d = args_q ? S_ARG : S_HDR;
      S_HDR: begin
        if (desc_rdata == '0 || kind == K_LINK) begin
          state_d = S_IDLE;
        end else if (kind == K_LOOP) begin
          loop_hit = 1'b1;
          if (loop_back) begin
            pc_d    = pc_q - DESC_AW'(desc_rdata[23:16]);
            state_d = S_FETCH;
          end else if (at_top) begin
            state_d = S_IDLE;
          end else begin
            pc_d    = pc_q + DESC_AW'(1);
            state_d = S_FETCH;
          end
        end else begin
          hdr_d  = desc_rdata[31:4];
          argi_d = 2'd0;
          need_d = (kind == K_RMW) ? 2'd3 : (desc_rdata[28] ? 2'd2 : 2'd1);
          if (at_top) begin
            state_d = S_IDLE;
          end else begin
            pc_d    = pc_q + DESC_AW'(1);
            args_d  = 1'b1;
            state_d = S_FETCH;
          end
        end
      end
      S_ARG: begin
        unique case (argi_q)
          2'd0: begin
            off_d = desc_rdata[9:2];
            len_d = desc_rdata[22:16];
          end
          2'd1:    a1_d = desc_rdata;
          default: a2_d = desc_rdata;
        endcase
        argi_d = argi_q + 2'd1;
        if (argi_d == need_q) begin
          args_d = 1'b0;
          ridx_d = '0;
          last_d = at_top;
          if (!at_top) pc_d = pc_q + DESC_AW'(1);
          if (hdr_q[27:26] == K_RMW) state_d = S_MRD;
          else if (hdr_q[24])        state_d = S_WR;
          else                       state_d = S_RD;
        end else if (at_top) begin
          state_d = S_IDLE;
        end else begin
          pc_d    = pc_q + DESC_AW'(1);
          state_d = S_FETCH;
        end
      end
      S_RD: begin
        if (cap_full) begin
          ovf_d   = 1'b1;
          state_d = S_IDLE;
        end else begin
          bus_req = 1'b1;
          if (bus_ack) begin
            cap_push = 1'b1;
            if (run_end) state_d = last_q ? S_IDLE : S_FETCH;
            else         ridx_d  = ridx_q + 7'd1;
          end
        end
      end
      S_WR: begin
        bus_req = 1'b1;
        if (bus_ack) state_d = last_q ? S_IDLE : S_FETCH;
      end
      S_MRD: begin
        if (cap_full) begin
          ovf_d   = 1'b1;
          state_d = S_IDLE;
        end else begin
          bus_req = 1'b1;
          if (bus_ack) begin
            cap_push = 1'b1;
            old_d    = bus_rdata;
            state_d  = S_MWR;
          end
        end
      end
      S_MWR: begin
        bus_req = 1'b1;
        if (bus_ack) state_d = last_q ? S_IDLE : S_FETCH;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pc_q    <= '0;
      hdr_q   <= '0;
      off_q   <= '0;
      len_q   <= '0;
      a1_q    <= '0;
      a2_q    <= '0;
      old_q   <= '0;
      argi_q  <= '0;
      need_q  <= '0;
      ridx_q  <= '0;
      args_q  <= 1'b0;
      last_q  <= 1'b0;
      ovf_q   <= 1'b0;
      crash_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      hdr_q   <= hdr_d;
      off_q   <= off_d;
      len_q   <= len_d;
      a1_q    <= a1_d;
      a2_q    <= a2_d;
      old_q   <= old_d;
      argi_q  <= argi_d;
      need_q  <= need_d;
      ridx_q  <= ridx_d;
      args_q  <= args_d;
      last_q  <= last_d;
      ovf_q   <= ovf_d;
      crash_q <= crash_trig;
    end
  end

endmodule

// File: rtl/capture_engine.sv
module capture_engine
  import cpe_pkg::*;
#(
  parameter int DESC_AW = 5,
  parameter int CAP_AW  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               sw_trig,
  input  logic               crash_trig,
  output logic [DESC_AW-1:0] desc_addr,
  input  logic [31:0]        desc_rdata,
  output logic               bus_req,
  output logic               bus_we,
  output logic               bus_alt,
  output logic [31:0]        bus_addr,
  output logic [31:0]        bus_wdata,
  input  logic               bus_ack,
  input  logic [31:0]        bus_rdata,
  output logic               cap_we,
  output logic [CAP_AW-1:0]  cap_addr,
  output logic [31:0]        cap_wdata,
  output logic [1:0]         status
);

  localparam int CNT_W = 8;

  logic [1:0]        rst_sync;
  logic              core_rst_n;
  logic              loop_hit, loop_back, run_clr, cap_push, cap_full;
  logic [CNT_W-1:0]  loop_cnt;
  logic [WORD_W-1:0] cap_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  cpe_ctrl #(.DESC_AW(DESC_AW), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rst_n(core_rst_n), .en(en), .sw_trig(sw_trig), .crash_trig(crash_trig),
    .desc_addr(desc_addr), .desc_rdata(desc_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_alt(bus_alt), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .status(status), .loop_hit(loop_hit), .loop_cnt(loop_cnt), .loop_back(loop_back),
    .run_clr(run_clr), .cap_push(cap_push), .cap_data(cap_data), .cap_full(cap_full)
  );

  cpe_loop #(.CNT_W(CNT_W)) i_loop (
    .clk(clk), .rst_n(core_rst_n), .clr(run_clr), .hit(loop_hit), .cnt(loop_cnt),
    .back(loop_back)
  );

  cpe_capture #(.AW(CAP_AW), .DW(WORD_W)) i_cap (
    .clk(clk), .rst_n(core_rst_n), .clr(run_clr), .push(cap_push), .din(cap_data),
    .full(cap_full), .cap_we(cap_we), .cap_addr(cap_addr), .cap_wdata(cap_wdata)
  );

endmodule

// File: rtl/cpe_checker.sv
module cpe_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        bus_req,
  input logic        bus_ack,
  input logic        bus_we,
  input logic [31:0] bus_addr,
  input logic        cap_we,
  input logic [1:0]  status
);

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !status[0] |-> !bus_req) else $error("idle with request"); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !status[0]) |-> !cap_we) else $error("capture after overflow"); // R9

  AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !status[0]) |=> !status[0]) else $error("start while disabled"); // R8

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)))
    else $error("request changed before ack"); // R10

  AST_CAPTURE_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we |-> $past(bus_ack && bus_req && !bus_we)) else $error("capture without read"); // R3

endmodule

bind capture_engine cpe_checker i_cpe_checker (
  .clk(clk), .rst_n(rst_n), .en(en), .bus_req(bus_req), .bus_ack(bus_ack),
  .bus_we(bus_we), .bus_addr(bus_addr), .cap_we(cap_we), .status(status)
);

// File: tb/test_capture_engine.sv
module test_capture_engine;

  localparam int DESC_AW = 5;
  localparam int CAP_AW  = 5;
  localparam int CAP_N   = 1 << CAP_AW;
  localparam logic [31:0] LINK = 32'hC000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, sw_trig = 1'b0, crash_trig = 1'b0;
  logic [DESC_AW-1:0] desc_addr;
  logic [31:0] desc_rdata = '0;
  logic bus_req, bus_we, bus_alt;
  logic [31:0] bus_addr, bus_wdata;
  logic bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic cap_we;
  logic [CAP_AW-1:0] cap_addr;
  logic [31:0] cap_wdata;
  logic [1:0] status;

  always #2.5 clk = ~clk;

  capture_engine #(.DESC_AW(DESC_AW), .CAP_AW(CAP_AW)) i_capture_engine (
    .clk(clk), .rst_n(rst_n), .en(en), .sw_trig(sw_trig), .crash_trig(crash_trig),
    .desc_addr(desc_addr), .desc_rdata(desc_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_alt(bus_alt), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .cap_we(cap_we), .cap_addr(cap_addr), .cap_wdata(cap_wdata), .status(status)
  );

  int checks = 0, errors = 0;
  logic [31:0] dmem [1<<DESC_AW];
  logic [31:0] tmem [256];
  logic [31:0] cmem [CAP_N];
  logic [31:0] ctr = '0;
  int cap_total = 0;
  int lat = 0, wcnt = 0, viol = 0;
  logic reinit = 1'b0, alt_seen = 1'b0;
  logic pend = 1'b0, pwe = 1'b0;
  logic [31:0] paddr = '0;

  function automatic logic [31:0] tinit(int i);
    return 32'h1000_0000 + 32'(i) * 32'h0001_0203;
  endfunction
  function automatic logic [31:0] hreg(bit alt, bit wr, logic [31:0] base);
    return {2'b00, alt, wr, base[27:4], 4'h0};
  endfunction
  function automatic logic [31:0] hrmw(logic [31:0] base);
    return {2'b10, 2'b00, base[27:4], 4'h0};
  endfunction
  function automatic logic [31:0] argw(int off, int len);
    return {9'h0, 7'(len), 6'h0, 8'(off), 2'b00};
  endfunction
  function automatic logic [31:0] loopw(int cnt, int span);
    return {2'b01, 6'h0, 8'(span), 8'h0, 8'(cnt)};
  endfunction

  // descriptor memory, registered read
  always @(posedge clk) desc_rdata <= dmem[desc_addr];

  // target: plain memory, word 255 is an incrementing counter
  always @(posedge clk) begin
    if (reinit) begin
      for (int i = 0; i < 256; i++) tmem[i] <= tinit(i);
      ctr <= '0;
    end
    bus_ack <= 1'b0;
    if (bus_req && !bus_ack) begin
      if (wcnt < lat) wcnt <= wcnt + 1;
      else begin
        wcnt     <= 0;
        bus_ack  <= 1'b1;
        alt_seen <= bus_alt;
        if (bus_we) tmem[bus_addr[9:2]] <= bus_wdata;
        else if (bus_addr[9:2] == 8'hFF) begin
          bus_rdata <= ctr;
          ctr <= ctr + 1;
        end else bus_rdata <= tmem[bus_addr[9:2]];
      end
    end
  end

  // capture SRAM model and handshake monitor (R10)
  always @(posedge clk) begin
    if (cap_we) begin
      cmem[cap_addr] <= cap_wdata;
      cap_total <= cap_total + 1;
    end
    if (pend && (!bus_req || bus_addr != paddr || bus_we != pwe)) viol <= viol + 1;
    pend  <= bus_req && !bus_ack;
    paddr <= bus_addr;
    pwe   <= bus_we;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_list();
    for (int i = 0; i < (1 << DESC_AW); i++) dmem[i] = '0;
  endtask

  task automatic do_reinit();
    @(negedge clk) reinit = 1'b1;
    @(negedge clk) reinit = 1'b0;
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 5000 && status[0]; t++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_sw(output int got);
    int s;
    s = cap_total;
    @(negedge clk) sw_trig = 1'b1;
    @(negedge clk) sw_trig = 1'b0;
    wait_idle();
    got = cap_total - s;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int got, n, idx, bad;
    logic [31:0] old, exp, m;
    clear_list();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_reinit();

    // R1 reset state
    chk(status == 2'b00, "R1 status", 32'(status), 0);
    chk(!bus_req, "R1 bus_req", 32'(bus_req), 0);
    chk(!cap_we, "R1 cap_we", 32'(cap_we), 0);
    en = 1'b1;

    // R3 read runs: sweep latency, base, offset and count
    for (int l = 0; l < 3; l += 2) begin
      lat = l;
      for (int b = 0; b < 2; b++) begin
        for (int o = 0; o < 6; o += 5) begin
          for (int len = 0; len < 10; len++) begin
            logic [31:0] base;
            base = (b == 0) ? 32'h100 : 32'h240;
            clear_list();
            dmem[0] = hreg(0, 0, base);
            dmem[1] = argw(o, len);
            dmem[2] = LINK;
            run_sw(got);
            n = (len == 0) ? 1 : len;
            chk(got == n, "R3 run count", 32'(got), 32'(n));
            bad = -1;
            for (int k = 0; k < n; k++)
              if (cmem[k] !== tinit(int'(base >> 2) + o + k) && bad < 0) bad = k;
            idx = (bad < 0) ? 0 : bad;
            chk(bad < 0, "R3 run data", cmem[idx], tinit(int'(base >> 2) + o + idx));
          end
        end
      end
    end
    lat = 1;

    // R4 write then read back; write itself logs nothing
    clear_list();
    dmem[0] = hreg(0, 1, 32'h200);
    dmem[1] = argw(2, 0);
    dmem[2] = 32'hDEAD_BEEF;
    dmem[3] = hreg(0, 0, 32'h200);
    dmem[4] = argw(2, 1);
    dmem[5] = LINK;
    run_sw(got);
    chk(got == 1, "R4 logged count", 32'(got), 1);
    chk(cmem[0] == 32'hDEAD_BEEF, "R4 written value", cmem[0], 32'hDEAD_BEEF);

    // R6 read-modify-write over several masks
    for (int mi = 0; mi < 4; mi++) begin
      do_reinit();
      m = (mi == 0) ? 32'h0000_FFFF : (mi == 1) ? 32'hF0F0_F0F0 : (mi == 2) ? 32'h0 : 32'hFFFF_FFFF;
      clear_list();
      dmem[0] = hrmw(32'h100);
      dmem[1] = argw(1, 0);
      dmem[2] = m;
      dmem[3] = 32'h1234_5678;
      dmem[4] = hreg(0, 0, 32'h100);
      dmem[5] = argw(1, 1);
      dmem[6] = LINK;
      run_sw(got);
      old = tinit(65);
      exp = (old & ~m) | (32'h1234_5678 & m);
      chk(got == 2, "R6 logged count", 32'(got), 2);
      chk(cmem[0] == old, "R6 old value logged", cmem[0], old);
      chk(cmem[1] == exp, "R6 merged value", cmem[1], exp);
    end

    // R7 loops over the counter register: passes show as 0,1,2,...
    for (int c = 0; c < 6; c++) begin
      do_reinit();
      clear_list();
      dmem[0] = hreg(0, 0, 32'h3F0);
      dmem[1] = argw(3, 1);
      dmem[2] = loopw(c, 2);
      dmem[3] = LINK;
      run_sw(got);
      n = (c < 2) ? 1 : c;
      chk(got == n, "R7 pass count", 32'(got), 32'(n));
      bad = -1;
      for (int k = 0; k < n; k++) if (cmem[k] != 32'(k) && bad < 0) bad = k;
      idx = (bad < 0) ? 0 : bad;
      chk(bad < 0, "R7 pass values", cmem[idx], 32'(idx));
    end

    // R2 link and all-zero words end the run
    do_reinit();
    clear_list();
    dmem[0] = hreg(0, 0, 32'h100);
    dmem[1] = argw(0, 1);
    dmem[2] = LINK;
    dmem[3] = hreg(0, 0, 32'h100);
    dmem[4] = argw(0, 1);
    run_sw(got);
    chk(got == 1, "R2 link ends run", 32'(got), 1);
    dmem[2] = 32'h0;
    run_sw(got);
    chk(got == 1, "R2 zero word ends run", 32'(got), 1);

    // R5 alternate bus bit
    clear_list();
    dmem[0] = hreg(1, 0, 32'h100);
    dmem[1] = argw(0, 1);
    dmem[2] = LINK;
    run_sw(got);
    chk(alt_seen == 1'b1, "R5 alt bus set", 32'(alt_seen), 1);
    dmem[0] = hreg(0, 0, 32'h100);
    run_sw(got);
    chk(alt_seen == 1'b0, "R5 alt bus clear", 32'(alt_seen), 0);

    // R9 capture overflow
    clear_list();
    dmem[0] = hreg(0, 0, 32'h100);
    dmem[1] = argw(0, 40);
    dmem[2] = LINK;
    run_sw(got);
    chk(got == CAP_N, "R9 overflow capture count", 32'(got), 32'(CAP_N));
    chk(status == 2'b10, "R9 overflow status", 32'(status), 32'h2);
    chk(cmem[CAP_N-1] == tinit(64 + CAP_N - 1), "R9 last word", cmem[CAP_N-1], tinit(64 + CAP_N - 1));
    dmem[1] = argw(0, 1);
    run_sw(got);
    chk(status == 2'b00, "R9 overflow cleared by new run", 32'(status), 0);

    // R8 disabled triggers are ignored
    en = 1'b0;
    n = cap_total;
    @(negedge clk) sw_trig = 1'b1;
    @(negedge clk) sw_trig = 1'b0;
    crash_trig = 1'b1;
    repeat (20) @(negedge clk);
    chk(status == 2'b00, "R8 disabled status", 32'(status), 0);
    chk(cap_total == n, "R8 disabled capture", 32'(cap_total - n), 0);
    crash_trig = 1'b0;
    @(negedge clk) en = 1'b1;

    // R8 held crash trigger runs once
    n = cap_total;
    @(negedge clk) crash_trig = 1'b1;
    @(negedge clk);
    chk(status[0] == 1'b1, "R8 crash starts run", 32'(status), 1);
    wait_idle();
    repeat (30) @(negedge clk);
    chk(cap_total - n == 1, "R8 crash single run", 32'(cap_total - n), 1);
    crash_trig = 1'b0;

    // R10 handshake stability across all traffic
    chk(viol == 0, "R10 request held until ack", 32'(viol), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule